// File: doc/BRIEF.md
# SPI Serial-Memory Command Front-End

This block is the command side of a 2K x 8 non-volatile memory that sits behind an SPI mode-0 slave port. The chip-select, serial clock and data-in pins are brought into one system clock domain and edge-detected there. Bits are taken from the data-in line on each rising serial clock. The block puts together an opcode byte, a 16-bit address field and the data bytes that follow. It decodes the opcode and starts the matching action.

Read-type commands stream bytes out on falling serial clock, MSB first. The bytes come from the array read port, from a hidden 2-bit output-voltage setting register, or from the status byte of the protection controller. Write-type commands hand each complete data byte to a page buffer. They raise a one-cycle commit request only when chip-select is released in the legal window that follows a whole data byte. Write-enable and write-disable opcodes become pulses to the status/protection controller. That controller owns the enable latch, the protection bits and the busy flag.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, so_oe is 0 and none of the pulse outputs (wren_p, wrdi_p, pb_wr, commit) fires until a frame is sent.
- R2: Opcode 0x06 gives one wren_p pulse and opcode 0x04 gives one wrdi_p pulse. The opcode counts only once its 8th bit has been clocked in, so a frame cut off after 7 bits gives no pulse.
- R3: Opcode 0x05 streams the status byte {4'b0000, bp[1], bp[0], wen, busy} MSB first. The first bit appears after the falling edge of the 8th clock, and the byte repeats, sampled afresh, for as long as clocking goes on.
- R4: Opcode 0x03, followed by a 16-bit address sent MSB first, streams the array byte at A10..A0, MSB first. The first bit appears after the falling edge of the 24th clock.
- R5: A read that keeps clocking returns consecutive array bytes, and the address wraps from 7FFh to 000h.
- R6: A read whose address field has any bit above A10 set (for example 0800h) returns {6'b000000, vset[1], vset[0]} in place of array data.
- R7: Opcode 0x02 with a 16-bit address, issued while wen=1 and busy=0, gives one pb_wr pulse for every complete data byte. pb_addr keeps A10..A5 of the address, and its low 5 bits start at A4..A0 and rise by one per byte, wrapping inside the 32-byte page.
- R8: commit pulses only when chip-select rises after the rising clock that completes a data byte and before the next rising clock. A rise during the opcode, during the address or inside a data byte cancels the command. commit_kind is 0 for array, 1 for status and 2 for the setting register.
- R9: Opcode 0x01 while wen=1 and busy=0 takes one data byte and, on a legal release, commits with commit_kind=1 and wr_byte holding that byte.
- R10: While wen=0, write opcodes are ignored. While busy=1, every opcode except 0x05 is ignored: no pulse, no page-buffer write, no commit and no driven output.
- R11: so_oe stays 0 during the opcode and the address, and returns to 0 once chip-select goes high, so a read can be abandoned at any point.
- R12: A write whose address field has a bit above A10 set targets the setting register. It gives no pb_wr, and on a legal release it commits with commit_kind=2 and the data byte on wr_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| csn | input | 1 | Chip-select pin, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the so pad driver |
| mem_rd_addr | output | 11 | Array read address |
| mem_rd_data | input | 8 | Array read data, combinational from mem_rd_addr |
| st_bp | input | 2 | Block-protection bits from the status controller |
| st_wen | input | 1 | Write-enable latch state |
| st_busy | input | 1 | Non-volatile cycle in progress |
| vset | input | 2 | Current output-voltage setting |
| wren_p | output | 1 | Write-enable command pulse |
| wrdi_p | output | 1 | Write-disable command pulse |
| pb_wr | output | 1 | Page-buffer byte write strobe |
| pb_addr | output | 11 | Page-buffer target address |
| wr_byte | output | 8 | Last complete data byte received |
| commit | output | 1 | Commit request pulse |
| commit_kind | output | 2 | Commit target: 0 array, 1 status, 2 setting |

## Verification
A pin edge reaches the edge detector after two synchroniser stages and one compare stage. The registered result follows one clock later, so so updates about four system clocks after a falling serial clock. The command pulses and pb_wr appear about four clocks after the rising clock that completes their byte, and commit appears one clock after the synchronised chip-select rise. The bench holds each serial clock level for eight system clocks. It samples so just before the next rising edge, and it samples pulse counters and so_oe at least eight clocks after the edge that causes them, so every check lands after its result has settled and before the next stimulus can disturb it.

// File: rtl/smf_pkg.sv
package smf_pkg;
  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_RD, PH_WR, PH_SKIP} phase_t;
  typedef enum logic [1:0] {SRC_MEM, SRC_SET, SRC_STAT} src_t;
  typedef enum logic [1:0] {KIND_ARRAY = 2'd0, KIND_STATUS = 2'd1, KIND_SETTING = 2'd2} kind_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  localparam int FIELD_W = 16;
endpackage

// File: rtl/smf_sync.sv
module smf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_end,
  output logic si_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b010;

  logic [NSIG-1:0] pin_in;
  logic [NSIG-1:0] pin_s;
  logic [NSIG-1:0] pin_prv;

  assign pin_in = {si, csn, sck};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], pin_in[g]};
    end
    assign pin_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prv <= IDLE_VAL;
    else        pin_prv <= pin_s;
  end

  assign sck_rise = pin_s[0] & ~pin_prv[0];
  assign sck_fall = ~pin_s[0] & pin_prv[0];
  assign cs_act   = ~pin_s[1];
  assign cs_end   = pin_s[1] & ~pin_prv[1];
  assign si_s     = pin_s[2];
endmodule

// File: rtl/smf_rx.sv
module smf_rx
  import smf_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PAGE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          cs_act,
  input  logic          cs_end,
  input  logic          si_s,
  input  logic          st_wen,
  input  logic          st_busy,
  output logic          wren_p,
  output logic          wrdi_p,
  output logic          load_req,
  output src_t          load_src,
  output logic [AW-1:0] rd_addr,
  output logic          pb_wr,
  output logic [AW-1:0] pb_addr,
  output logic [7:0]    wr_byte,
  output logic          commit,
  output kind_t         commit_kind
);
  localparam int HI_W = AW - PAGE_BITS;

  phase_t               phase, phase_n;
  logic [3:0]           cnt, cnt_n;
  logic [FIELD_W-2:0]   sh, sh_n;
  logic                 rd_cmd, rd_cmd_n;
  kind_t                wkind, wkind_n;
  logic [HI_W-1:0]      page, page_n;
  logic [PAGE_BITS-1:0] off, off_n;
  logic                 arm, arm_n;
  logic                 wren_n, wrdi_n, load_n, pb_wr_n, commit_n;
  src_t                 src_n;
  kind_t                ckind_n;
  logic [AW-1:0]        rd_addr_n, pb_addr_n;
  logic [7:0]           wr_byte_n;

  logic [FIELD_W-1:0]   sh_in;
  logic [7:0]           byte_in;
  logic                 hidden_sel;
  logic                 wr_ok, cmd_ok;

  assign sh_in      = {sh, si_s};
  assign byte_in    = sh_in[7:0];
  assign hidden_sel = |sh_in[FIELD_W-1:AW];
  assign cmd_ok     = !st_busy;
  assign wr_ok      = st_wen && !st_busy;

  always_comb begin
    phase_n   = phase;
    cnt_n     = cnt;
    sh_n      = sh;
    rd_cmd_n  = rd_cmd;
    wkind_n   = wkind;
    page_n    = page;
    off_n     = off;
    arm_n     = arm;
    src_n     = load_src;
    rd_addr_n = rd_addr;
    pb_addr_n = pb_addr;
    wr_byte_n = wr_byte;
    ckind_n   = commit_kind;
    wren_n    = 1'b0;
    wrdi_n    = 1'b0;
    load_n    = 1'b0;
    pb_wr_n   = 1'b0;
    commit_n  = 1'b0;

    if (!cs_act) begin
      phase_n = PH_OP;
      cnt_n   = '0;
      arm_n   = 1'b0;
      if (cs_end && arm) begin
        commit_n = 1'b1;
        ckind_n  = wkind;
      end
    end else begin
      if (load_req && load_src == SRC_MEM) rd_addr_n = rd_addr + 1'b1;
      if (sck_rise) begin
        sh_n  = sh_in[FIELD_W-2:0];
        cnt_n = cnt + 1'b1;
        case (phase)
          PH_OP: begin
            if (cnt == 4'd7) begin
              cnt_n   = '0;
              phase_n = PH_SKIP;
              case (byte_in)
                OP_WREN: wren_n = cmd_ok;
                OP_WRDI: wrdi_n = cmd_ok;
                OP_READ: begin
                  if (cmd_ok) begin
                    phase_n  = PH_ADDR;
                    rd_cmd_n = 1'b1;
                  end
                end
                OP_WRITE: begin
                  if (wr_ok) begin
                    phase_n  = PH_ADDR;
                    rd_cmd_n = 1'b0;
                  end
                end
                OP_RDSR: begin
                  phase_n = PH_RD;
                  load_n  = 1'b1;
                  src_n   = SRC_STAT;
                end
                OP_WRSR: begin
                  if (wr_ok) begin
                    phase_n = PH_WR;
                    wkind_n = KIND_STATUS;
                  end
                end
                default: phase_n = PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            if (cnt == 4'd15) begin
              cnt_n = '0;
              if (rd_cmd) begin
                phase_n   = PH_RD;
                load_n    = 1'b1;
                src_n     = hidden_sel ? SRC_SET : SRC_MEM;
                rd_addr_n = sh_in[AW-1:0];
              end else begin
                phase_n = PH_WR;
                wkind_n = hidden_sel ? KIND_SETTING : KIND_ARRAY;
                page_n  = sh_in[AW-1:PAGE_BITS];
                off_n   = sh_in[PAGE_BITS-1:0];
              end
            end
          end
          PH_RD: begin
            if (cnt == 4'd7) begin
              cnt_n  = '0;
              load_n = 1'b1;
            end
          end
          PH_WR: begin
            arm_n = (cnt == 4'd7);
            if (cnt == 4'd7) begin
              cnt_n     = '0;
              wr_byte_n = byte_in;
              if (wkind == KIND_ARRAY) begin
                pb_wr_n   = 1'b1;
                pb_addr_n = {page, off};
                off_n     = off + 1'b1;
              end
            end
          end
          default: cnt_n = cnt;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OP;
      cnt         <= '0;
      sh          <= '0;
      rd_cmd      <= 1'b0;
      wkind       <= KIND_ARRAY;
      page        <= '0;
      off         <= '0;
      arm         <= 1'b0;
      wren_p      <= 1'b0;
      wrdi_p      <= 1'b0;
      load_req    <= 1'b0;
      load_src    <= SRC_MEM;
      rd_addr     <= '0;
      pb_wr       <= 1'b0;
      pb_addr     <= '0;
      wr_byte     <= '0;
      commit      <= 1'b0;
      commit_kind <= KIND_ARRAY;
    end else begin
      phase       <= phase_n;
      cnt         <= cnt_n;
      sh          <= sh_n;
      rd_cmd      <= rd_cmd_n;
      wkind       <= wkind_n;
      page        <= page_n;
      off         <= off_n;
      arm         <= arm_n;
      wren_p      <= wren_n;
      wrdi_p      <= wrdi_n;
      load_req    <= load_n;
      load_src    <= src_n;
      rd_addr     <= rd_addr_n;
      pb_wr       <= pb_wr_n;
      pb_addr     <= pb_addr_n;
      wr_byte     <= wr_byte_n;
      commit      <= commit_n;
      commit_kind <= ckind_n;
    end
  end
endmodule

// File: rtl/smf_tx.sv
module smf_tx
  import smf_pkg::*;
#(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sck_fall,
  input  logic             load_req,
  input  src_t             load_src,
  input  logic [7:0]       mem_rd_data,
  input  logic [SET_W-1:0] vset,
  input  logic [7:0]       status_byte,
  output logic             so,
  output logic             so_oe
);
  logic [7:0] outsh, outsh_n;
  logic       loaded, loaded_n;
  logic       so_n, oe_n;
  logic [7:0] src_byte;

  always_comb begin
    case (load_src)
      SRC_MEM:  src_byte = mem_rd_data;
      SRC_SET:  src_byte = {{(8-SET_W){1'b0}}, vset};
      SRC_STAT: src_byte = status_byte;
      default:  src_byte = '0;
    endcase
  end

  always_comb begin
    outsh_n  = outsh;
    loaded_n = loaded;
    so_n     = so;
    oe_n     = so_oe;
    if (!cs_act) begin
      loaded_n = 1'b0;
      oe_n     = 1'b0;
    end else if (load_req) begin
      outsh_n  = src_byte;
      loaded_n = 1'b1;
    end else if (sck_fall && loaded) begin
      so_n    = outsh[7];
      outsh_n = {outsh[6:0], 1'b0};
      oe_n    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outsh  <= '0;
      loaded <= 1'b0;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else begin
      outsh  <= outsh_n;
      loaded <= loaded_n;
      so     <= so_n;
      so_oe  <= oe_n;
    end
  end
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import smf_pkg::*;
#(
  parameter int AW          = 11,
  parameter int PAGE_BITS   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SET_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             csn,
  input  logic             si,
  output logic             so,
  output logic             so_oe,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [7:0]       mem_rd_data,
  input  logic [1:0]       st_bp,
  input  logic             st_wen,
  input  logic             st_busy,
  input  logic [SET_W-1:0] vset,
  output logic             wren_p,
  output logic             wrdi_p,
  output logic             pb_wr,
  output logic [AW-1:0]    pb_addr,
  output logic [7:0]       wr_byte,
  output logic             commit,
  output logic [1:0]       commit_kind
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  logic       sck_rise, sck_fall, cs_act, cs_end, si_s;
  logic       load_req;
  src_t       load_src;
  kind_t      kind_w;
  logic [7:0] status_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign status_byte = {4'b0000, st_bp, st_wen, st_busy};

  smf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sck      (sck),
    .csn      (csn),
    .si       (si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .cs_end   (cs_end),
    .si_s     (si_s)
  );

  smf_rx #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sck_rise    (sck_rise),
    .cs_act      (cs_act),
    .cs_end      (cs_end),
    .si_s        (si_s),
    .st_wen      (st_wen),
    .st_busy     (st_busy),
    .wren_p      (wren_p),
    .wrdi_p      (wrdi_p),
    .load_req    (load_req),
    .load_src    (load_src),
    .rd_addr     (mem_rd_addr),
    .pb_wr       (pb_wr),
    .pb_addr     (pb_addr),
    .wr_byte     (wr_byte),
    .commit      (commit),
    .commit_kind (kind_w)
  );

  assign commit_kind = kind_w;

  smf_tx #(.SET_W(SET_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .cs_act      (cs_act),
    .sck_fall    (sck_fall),
    .load_req    (load_req),
    .load_src    (load_src),
    .mem_rd_data (mem_rd_data),
    .vset        (vset),
    .status_byte (status_byte),
    .so          (so),
    .so_oe       (so_oe)
  );
endmodule

// File: rtl/smf_chk.sv
module smf_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic cs_end,
  input logic sck_fall,
  input logic so_oe,
  input logic commit,
  input logic wren_p,
  input logic wrdi_p,
  input logic pb_wr
);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

  // R11
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));

  // R8
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_end));

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_p, wrdi_p, commit}));

  // R7
  pb_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr |-> $past(cs_act));
endmodule

bind spi_mem_frontend smf_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .cs_end   (cs_end),
  .sck_fall (sck_fall),
  .so_oe    (so_oe),
  .commit   (commit),
  .wren_p   (wren_p),
  .wrdi_p   (wrdi_p),
  .pb_wr    (pb_wr)
);

// File: tb/tb_spi_mem_frontend.sv
module tb_spi_mem_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        csn = 1'b1;
  logic        si = 1'b0;
  logic        so, so_oe;
  logic [10:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic [1:0]  st_bp = 2'b00;
  logic        st_wen = 1'b0;
  logic        st_busy = 1'b0;
  logic [1:0]  vset = 2'b10;
  logic        wren_p, wrdi_p, pb_wr, commit;
  logic [10:0] pb_addr;
  logic [7:0]  wr_byte;
  logic [1:0]  commit_kind;

  int n_chk = 0;
  int n_err = 0;
  int n_wren = 0, n_wrdi = 0, n_pb = 0, n_commit = 0, n_oe = 0;
  logic [10:0] first_pb_addr, last_pb_addr;
  logic [7:0]  last_pb_data, last_cbyte;
  logic [1:0]  last_kind;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_model(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  assign mem_rd_data = mem_model(mem_rd_addr);

  spi_mem_frontend dut (
    .clk (clk), .rst_n (rst_n), .sck (sck), .csn (csn), .si (si),
    .so (so), .so_oe (so_oe), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
    .st_bp (st_bp), .st_wen (st_wen), .st_busy (st_busy), .vset (vset),
    .wren_p (wren_p), .wrdi_p (wrdi_p), .pb_wr (pb_wr), .pb_addr (pb_addr),
    .wr_byte (wr_byte), .commit (commit), .commit_kind (commit_kind)
  );

  always @(posedge clk) begin
    if (wren_p) n_wren++;
    if (wrdi_p) n_wrdi++;
    if (so_oe) n_oe++;
    if (pb_wr) begin
      if (n_pb == 0) first_pb_addr = pb_addr;
      n_pb++;
      last_pb_addr = pb_addr;
      last_pb_data = wr_byte;
    end
    if (commit) begin
      n_commit++;
      last_kind  = commit_kind;
      last_cbyte = wr_byte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_begin();
    @(negedge clk);
    csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (8) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      si = tx[7-i];
      repeat (7) @(negedge clk);
      rx[7-i] = so;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  localparam logic [15:0] RD_VEC [6] = '{16'h0000, 16'h0123, 16'h07FE, 16'h0800, 16'h07FF, 16'h4555};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  rb;
    logic [10:0] ea;
    logic [7:0]  eb;
    int          pb0, c0, oe0;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk("R1 so_oe", so_oe, 0);
    chk("R1 pulses", n_wren + n_wrdi + n_pb + n_commit, 0);

    // R2 enable / disable opcodes
    frame_begin(); xfer(8'h06, 8, rb); frame_end();
    chk("R2 wren", n_wren, 1);
    frame_begin(); xfer(8'h04, 8, rb); frame_end();
    chk("R2 wrdi", n_wrdi, 1);
    frame_begin(); xfer(8'h06, 7, rb); frame_end();
    chk("R2 short frame", n_wren, 1);

    // R3 status stream
    st_bp = 2'b10; st_wen = 1'b1;
    frame_begin(); xfer(8'h05, 8, rb);
    xfer(8'h00, 8, rb); chk("R3 status byte0", rb, 8'h0A);
    xfer(8'h00, 8, rb); chk("R3 status byte1", rb, 8'h0A);
    frame_end();

    // R4 R5 R6 vector table of read frames
    foreach (RD_VEC[v]) begin
      string lbl;
      if (|RD_VEC[v][15:11]) lbl = "R6 setting read";
      else if (RD_VEC[v][10:0] >= 11'h7FE) lbl = "R5 wrap read";
      else lbl = "R4 array read";
      frame_begin();
      xfer(8'h03, 8, rb);
      xfer(RD_VEC[v][15:8], 8, rb);
      xfer(RD_VEC[v][7:0], 8, rb);
      for (int k = 0; k < 3; k++) begin
        xfer(8'h00, 8, rb);
        ea = RD_VEC[v][10:0] + 11'(k);
        eb = (|RD_VEC[v][15:11]) ? {6'b0, vset} : mem_model(ea);
        chk(lbl, rb, eb);
      end
      frame_end();
    end

    // R11 no drive during header, release on abandon
    frame_begin();
    xfer(8'h03, 8, rb);
    chk("R11 oe during opcode", so_oe, 0);
    xfer(8'h00, 8, rb); xfer(8'h10, 8, rb);
    xfer(8'h00, 4, rb);
    chk("R11 oe while streaming", so_oe, 1);
    frame_end();
    chk("R11 oe after abandon", so_oe, 0);

    // R7 R8 page write with wrap
    st_wen = 1'b1;
    pb0 = n_pb; c0 = n_commit;
    frame_begin();
    xfer(8'h02, 8, rb); xfer(8'h07, 8, rb); xfer(8'hE3, 8, rb);
    for (int i = 0; i < 30; i++) xfer(8'h40 + 8'(i), 8, rb);
    frame_end();
    chk("R7 byte count", n_pb - pb0, 30);
    chk("R7 first addr", first_pb_addr, 11'h7E3);
    chk("R7 page wrap addr", last_pb_addr, 11'h7E0);
    chk("R7 last data", last_pb_data, 8'h5D);
    chk("R8 commit legal", n_commit - c0, 1);
    chk("R8 kind array", last_kind, 2'd0);

    // R8 cancel inside a byte and inside the address
    pb0 = n_pb; c0 = n_commit;
    frame_begin();
    xfer(8'h02, 8, rb); xfer(8'h00, 8, rb); xfer(8'h10, 8, rb);
    xfer(8'h55, 8, rb); xfer(8'hAA, 4, rb);
    frame_end();
    chk("R8 cancel mid byte", n_commit - c0, 0);
    chk("R8 byte before cancel", n_pb - pb0, 1);
    frame_begin(); xfer(8'h02, 8, rb); xfer(8'h00, 8, rb); frame_end();
    chk("R8 cancel in address", n_commit - c0, 0);

    // R9 status write
    c0 = n_commit;
    frame_begin(); xfer(8'h01, 8, rb); xfer(8'h0C, 8, rb); frame_end();
    chk("R9 commit", n_commit - c0, 1);
    chk("R9 kind", last_kind, 2'd1);
    chk("R9 byte", last_cbyte, 8'h0C);

    // R12 setting write
    pb0 = n_pb; c0 = n_commit;
    frame_begin();
    xfer(8'h02, 8, rb); xfer(8'h08, 8, rb); xfer(8'h00, 8, rb); xfer(8'h03, 8, rb);
    frame_end();
    chk("R12 commit", n_commit - c0, 1);
    chk("R12 kind", last_kind, 2'd2);
    chk("R12 byte", last_cbyte, 8'h03);
    chk("R12 no page write", n_pb - pb0, 0);

    // R10 gating by enable latch and busy flag
    st_wen = 1'b0;
    pb0 = n_pb; c0 = n_commit;
    frame_begin();
    xfer(8'h02, 8, rb); xfer(8'h00, 8, rb); xfer(8'h20, 8, rb); xfer(8'h99, 8, rb);
    frame_end();
    chk("R10 wen0 page", n_pb - pb0, 0);
    chk("R10 wen0 commit", n_commit - c0, 0);

    st_wen = 1'b1; st_busy = 1'b1;
    frame_begin();
    xfer(8'h02, 8, rb); xfer(8'h00, 8, rb); xfer(8'h20, 8, rb); xfer(8'h99, 8, rb);
    frame_end();
    chk("R10 busy page", n_pb - pb0, 0);
    chk("R10 busy commit", n_commit - c0, 0);
    frame_begin(); xfer(8'h06, 8, rb); frame_end();
    chk("R10 busy wren", n_wren, 1);
    oe0 = n_oe;
    frame_begin();
    xfer(8'h03, 8, rb); xfer(8'h00, 8, rb); xfer(8'h00, 8, rb); xfer(8'h00, 8, rb);
    frame_end();
    chk("R10 busy read no drive", n_oe - oe0, 0);
    frame_begin(); xfer(8'h05, 8, rb); xfer(8'h00, 8, rb); frame_end();
    chk("R10 R3 status while busy", rb, 8'h0B);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule